// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address for a load, store, instruction fetch or atomic swap, issued from either user or privileged mode. The caller hands over one request at a time through a valid/ready handshake. The walker then reads a first-level and a second-level page table entry through a 32-bit memory read port. It checks the second-level entry against the access kind and mode, and returns either a physical address or a fault. A fault carries a cause code and the faulting virtual address.

When a translation succeeds and the page's accessed flag is clear, or a store-class access finds the dirty flag clear, the walker issues one compare-and-swap to the second-level entry. The compare value is the entry it read and the new value is that entry with the missing flags set. The walker then completes without looking at whether the swap won.

Two control inputs shape the walk. An enable input selects identity mapping when it is low. A table base register sets where the first-level table starts, and writes to it are forced to 4 KB alignment.

Top module: `pt_walker`

## Requirements
- R1: With `xlat_en_i` low when a request is accepted, the response returns `rsp_pa_o` equal to the virtual address and no fault, and no memory read or swap is issued.
- R2: The first-level read goes to base + 4×VA[31:22]. The second-level read goes to {L1 entry[31:12], 12'h000} + 4×VA[21:12], so bits 11:0 of the first-level entry do not affect the address.
- R3: An entry at either level whose bit 0 (present) is clear ends the walk with a page fault. A first-level miss issues no second-level read.
- R4: A user-mode access (`req_user_i`=1) to a present page whose bit 5 (user) is clear raises a privileged page fault, whatever the permission bits say.
- R5: A present page that passes the mode check faults as a page fault when the permission for the access kind is clear. The bits are: bit 2 read for loads, bit 3 write for stores and swaps, bit 4 execute for fetches.
- R6: `req_kind_i` encodes 0 load, 1 store, 2 fetch, 3 swap, and a swap is checked as a store. Page fault causes are 0x00002002 (load), 0x00003002 (store/swap) and 0x00000002 (fetch). Privileged page fault causes are 0x00002003, 0x00003003 and 0x00000003.
- R7: On success, bit 1 (accessed) is added when clear, and bit 7 (dirty) is added when clear for a store or swap. If anything is added, exactly one swap is issued to the second-level entry address with compare = old entry and new = old entry | added bits. Its outcome is ignored and it is never retried. No swap is issued on a fault or when nothing is added.
- R8: A successful translation returns {L2 entry[31:12], VA[11:0]}.
- R9: A base register write keeps only bits 31:12 of `base_wdata_i` and clears the low 12 bits.
- R10: After reset `req_ready_o` is high and no request or response is active. `req_ready_o` is high only while idle. Each accepted request yields exactly one single-cycle `rsp_valid_o` pulse, with `rsp_va_o` equal to the request's address, and the walker is idle again on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xlat_en_i | input | 1 | Translation enable, sampled at request acceptance |
| base_wr_i | input | 1 | Table base register write strobe |
| base_wdata_i | input | 32 | Table base write data (low 12 bits dropped) |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Walker idle and able to accept |
| req_va_i | input | 32 | Virtual address |
| req_kind_i | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 swap |
| req_user_i | input | 1 | 1 = user mode, 0 = privileged |
| rd_req_o | output | 1 | Memory read request, held until acknowledged |
| rd_addr_o | output | 32 | Memory read word address |
| rd_ack_i | input | 1 | Read acknowledge; data valid in the same cycle |
| rd_data_i | input | 32 | Read data |
| cas_req_o | output | 1 | Compare-and-swap request, held until acknowledged |
| cas_addr_o | output | 32 | Swap target address |
| cas_cmp_o | output | 32 | Swap compare value |
| cas_new_o | output | 32 | Swap new value |
| cas_ack_i | input | 1 | Swap acknowledge (outcome not reported) |
| rsp_valid_o | output | 1 | Single-cycle response strobe |
| rsp_fault_o | output | 1 | Response is a fault |
| rsp_cause_o | output | 32 | Fault cause code |
| rsp_pa_o | output | 32 | Physical address on success |
| rsp_va_o | output | 32 | Virtual address of the request |

## Verification
The bench builds the walker with its default split of 10 first-level index bits, 10 second-level index bits and a 12-bit offset. That makes the full 32-bit format the one under test. The second-level entry's seven meaningful flag bits (present, accessed, read, write, execute, user, dirty) are swept through all 128 values, for each of the four access kinds and both modes, with memory latency cycling through 0 to 2 cycles. This covers every ordering of the present, mode and permission checks and every accessed/dirty update combination. Separate runs cover a first-level miss, identity mapping, and a swap that the bench deliberately makes lose, to show the walker neither retries nor changes its result.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_SWAP  = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_L1, S_L2, S_CAS, S_DONE
  } walk_state_e;

  localparam int PTE_P = 0;
  localparam int PTE_A = 1;
  localparam int PTE_R = 2;
  localparam int PTE_W = 3;
  localparam int PTE_X = 4;
  localparam int PTE_U = 5;
  localparam int PTE_D = 7;

  localparam logic [31:0] GRP_LOAD  = 32'h0000_2000;
  localparam logic [31:0] GRP_STORE = 32'h0000_3000;
  localparam logic [31:0] GRP_FETCH = 32'h0000_0000;
  localparam logic [31:0] SUB_PF    = 32'h0000_0002;
  localparam logic [31:0] SUB_PPF   = 32'h0000_0003;

  function automatic logic is_store_class(acc_kind_e k);
    return (k == ACC_STORE) || (k == ACC_SWAP);
  endfunction

  function automatic logic [31:0] fault_cause(acc_kind_e k, logic priv);
    logic [31:0] grp;
    case (k)
      ACC_LOAD:  grp = GRP_LOAD;
      ACC_FETCH: grp = GRP_FETCH;
      default:   grp = GRP_STORE;
    endcase
    return grp | (priv ? SUB_PPF : SUB_PF);
  endfunction
endpackage

// File: rtl/pw_base_reg.sv
module pw_base_reg #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] base_o
);
  logic [ADDR_W-OFF_W-1:0] page_q;
  logic                    unused_low;

  assign unused_low = ^wdata_i[OFF_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   page_q <= '0;
    else if (wr_i) page_q <= wdata_i[ADDR_W-1:OFF_W];
  end

  assign base_o = {page_q, {OFF_W{1'b0}}};
endmodule

// File: rtl/pw_pte_check.sv
module pw_pte_check
  import pw_pkg::*;
#(
  parameter int PTE_W_BITS = 32
) (
  input  logic [PTE_W_BITS-1:0] pte_i,
  input  acc_kind_e             kind_i,
  input  logic                  user_i,
  output logic                  fault_o,
  output logic                  priv_o,
  output logic                  upd_o,
  output logic [PTE_W_BITS-1:0] pte_new_o
);
  logic                  perm_ok;
  logic [PTE_W_BITS-1:0] add_bits;

  always_comb begin
    case (kind_i)
      ACC_LOAD:  perm_ok = pte_i[PTE_R];
      ACC_FETCH: perm_ok = pte_i[PTE_X];
      default:   perm_ok = pte_i[PTE_W];
    endcase
    // order: present, then mode, then permission
    priv_o  = pte_i[PTE_P] && user_i && !pte_i[PTE_U];
    fault_o = !pte_i[PTE_P] || priv_o || !perm_ok;

    add_bits = '0;
    if (!pte_i[PTE_A]) add_bits[PTE_A] = 1'b1;
    if (is_store_class(kind_i) && !pte_i[PTE_D]) add_bits[PTE_D] = 1'b1;
    upd_o     = |add_bits;
    pte_new_o = pte_i | add_bits;
  end
endmodule

// File: rtl/pw_walk_fsm.sv
module pw_walk_fsm
  import pw_pkg::*;
#(
  parameter int L1_W = 10,
  parameter int L2_W = 10,
  parameter int OFF_W = 12,
  parameter int ENTRY_SH = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          xlat_en_i,
  input  logic [L1_W+L2_W+OFF_W-1:0]    base_i,
  input  logic                          req_valid_i,
  output logic                          req_ready_o,
  input  logic [L1_W+L2_W+OFF_W-1:0]    req_va_i,
  input  logic [1:0]                    req_kind_i,
  input  logic                          req_user_i,
  output logic                          rd_req_o,
  output logic [L1_W+L2_W+OFF_W-1:0]    rd_addr_o,
  input  logic                          rd_ack_i,
  input  logic [L1_W+L2_W+OFF_W-1:0]    rd_data_i,
  output logic                          cas_req_o,
  output logic [L1_W+L2_W+OFF_W-1:0]    cas_addr_o,
  output logic [L1_W+L2_W+OFF_W-1:0]    cas_cmp_o,
  output logic [L1_W+L2_W+OFF_W-1:0]    cas_new_o,
  input  logic                          cas_ack_i,
  output acc_kind_e                     kind_o,
  output logic                          user_o,
  input  logic                          chk_fault_i,
  input  logic                          chk_priv_i,
  input  logic                          chk_upd_i,
  input  logic [L1_W+L2_W+OFF_W-1:0]    chk_pte_new_i,
  output logic                          rsp_valid_o,
  output logic                          rsp_fault_o,
  output logic [31:0]                   rsp_cause_o,
  output logic [L1_W+L2_W+OFF_W-1:0]    rsp_pa_o,
  output logic [L1_W+L2_W+OFF_W-1:0]    rsp_va_o
);
  localparam int ADDR_W = L1_W + L2_W + OFF_W;

  walk_state_e       state_q;
  logic [ADDR_W-1:0] va_q, pa_q, l2_base_q;
  logic [ADDR_W-1:0] cas_addr_q, cas_cmp_q, cas_new_q;
  acc_kind_e         kind_q;
  logic              user_q, fault_q;
  logic [31:0]       cause_q;
  logic [ADDR_W-1:0] l1_off, l2_off;

  assign l1_off = ADDR_W'({va_q[ADDR_W-1 -: L1_W], {ENTRY_SH{1'b0}}});
  assign l2_off = ADDR_W'({va_q[OFF_W +: L2_W], {ENTRY_SH{1'b0}}});

  always_comb begin
    rd_req_o  = 1'b0;
    rd_addr_o = base_i + l1_off;
    case (state_q)
      S_L1: rd_req_o = 1'b1;
      S_L2: begin
        rd_req_o  = 1'b1;
        rd_addr_o = l2_base_q + l2_off;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      va_q       <= '0;
      pa_q       <= '0;
      l2_base_q  <= '0;
      cas_addr_q <= '0;
      cas_cmp_q  <= '0;
      cas_new_q  <= '0;
      kind_q     <= ACC_LOAD;
      user_q     <= 1'b0;
      fault_q    <= 1'b0;
      cause_q    <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (req_valid_i) begin
          va_q    <= req_va_i;
          kind_q  <= acc_kind_e'(req_kind_i);
          user_q  <= req_user_i;
          fault_q <= 1'b0;
          cause_q <= '0;
          if (xlat_en_i) begin
            pa_q    <= '0;
            state_q <= S_L1;
          end else begin
            pa_q    <= req_va_i;
            state_q <= S_DONE;
          end
        end
        S_L1: if (rd_ack_i) begin
          if (!rd_data_i[PTE_P]) begin
            fault_q <= 1'b1;
            cause_q <= fault_cause(kind_q, 1'b0);
            state_q <= S_DONE;
          end else begin
            l2_base_q <= {rd_data_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
            state_q   <= S_L2;
          end
        end
        S_L2: if (rd_ack_i) begin
          if (chk_fault_i) begin
            fault_q <= 1'b1;
            cause_q <= fault_cause(kind_q, chk_priv_i);
            state_q <= S_DONE;
          end else begin
            pa_q <= {rd_data_i[ADDR_W-1:OFF_W], va_q[OFF_W-1:0]};
            if (chk_upd_i) begin
              cas_addr_q <= rd_addr_o;
              cas_cmp_q  <= rd_data_i;
              cas_new_q  <= chk_pte_new_i;
              state_q    <= S_CAS;
            end else begin
              state_q <= S_DONE;
            end
          end
        end
        // single attempt; result of the swap is not consulted
        S_CAS: if (cas_ack_i) state_q <= S_DONE;
        S_DONE: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == S_IDLE);
  assign cas_req_o   = (state_q == S_CAS);
  assign cas_addr_o  = cas_addr_q;
  assign cas_cmp_o   = cas_cmp_q;
  assign cas_new_o   = cas_new_q;
  assign kind_o      = kind_q;
  assign user_o      = user_q;
  assign rsp_valid_o = (state_q == S_DONE);
  assign rsp_fault_o = fault_q;
  assign rsp_cause_o = cause_q;
  assign rsp_pa_o    = pa_q;
  assign rsp_va_o    = va_q;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pw_pkg::*;
#(
  parameter int L1_W  = 10,
  parameter int L2_W  = 10,
  parameter int OFF_W = 12
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        xlat_en_i,
  input  logic        base_wr_i,
  input  logic [31:0] base_wdata_i,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic [31:0] req_va_i,
  input  logic [1:0]  req_kind_i,
  input  logic        req_user_i,
  output logic        rd_req_o,
  output logic [31:0] rd_addr_o,
  input  logic        rd_ack_i,
  input  logic [31:0] rd_data_i,
  output logic        cas_req_o,
  output logic [31:0] cas_addr_o,
  output logic [31:0] cas_cmp_o,
  output logic [31:0] cas_new_o,
  input  logic        cas_ack_i,
  output logic        rsp_valid_o,
  output logic        rsp_fault_o,
  output logic [31:0] rsp_cause_o,
  output logic [31:0] rsp_pa_o,
  output logic [31:0] rsp_va_o
);
  localparam int ADDR_W = L1_W + L2_W + OFF_W;

  logic [ADDR_W-1:0] base;
  acc_kind_e         kind;
  logic              user, chk_fault, chk_priv, chk_upd;
  logic [ADDR_W-1:0] chk_pte_new;

  pw_base_reg #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_base (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (base_wr_i),
    .wdata_i (base_wdata_i),
    .base_o  (base)
  );

  pw_pte_check #(.PTE_W_BITS(ADDR_W)) u_check (
    .pte_i     (rd_data_i),
    .kind_i    (kind),
    .user_i    (user),
    .fault_o   (chk_fault),
    .priv_o    (chk_priv),
    .upd_o     (chk_upd),
    .pte_new_o (chk_pte_new)
  );

  pw_walk_fsm #(.L1_W(L1_W), .L2_W(L2_W), .OFF_W(OFF_W), .ENTRY_SH(2)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .xlat_en_i     (xlat_en_i),
    .base_i        (base),
    .req_valid_i   (req_valid_i),
    .req_ready_o   (req_ready_o),
    .req_va_i      (req_va_i),
    .req_kind_i    (req_kind_i),
    .req_user_i    (req_user_i),
    .rd_req_o      (rd_req_o),
    .rd_addr_o     (rd_addr_o),
    .rd_ack_i      (rd_ack_i),
    .rd_data_i     (rd_data_i),
    .cas_req_o     (cas_req_o),
    .cas_addr_o    (cas_addr_o),
    .cas_cmp_o     (cas_cmp_o),
    .cas_new_o     (cas_new_o),
    .cas_ack_i     (cas_ack_i),
    .kind_o        (kind),
    .user_o        (user),
    .chk_fault_i   (chk_fault),
    .chk_priv_i    (chk_priv),
    .chk_upd_i     (chk_upd),
    .chk_pte_new_i (chk_pte_new),
    .rsp_valid_o   (rsp_valid_o),
    .rsp_fault_o   (rsp_fault_o),
    .rsp_cause_o   (rsp_cause_o),
    .rsp_pa_o      (rsp_pa_o),
    .rsp_va_o      (rsp_va_o)
  );
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_ready_o,
  input logic        rd_req_o,
  input logic [31:0] rd_addr_o,
  input logic        rd_ack_i,
  input logic        cas_req_o,
  input logic [31:0] cas_addr_o,
  input logic [31:0] cas_cmp_o,
  input logic [31:0] cas_new_o,
  input logic        cas_ack_i,
  input logic        rsp_valid_o,
  input logic        rsp_fault_o,
  input logic [31:0] rsp_cause_o,
  input logic [31:0] rsp_pa_o,
  input logic [31:0] rsp_va_o
);
  assert_rsp_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o && req_ready_o);

  assert_busy_not_ready_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o || cas_req_o || rsp_valid_o) |-> !req_ready_o);

  assert_one_port_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req_o && cas_req_o));

  assert_rd_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_ack_i) |=> rd_req_o && $stable(rd_addr_o));

  assert_rd_word_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> rd_addr_o[1:0] == 2'b00);

  assert_cas_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cas_req_o && !cas_ack_i) |=> cas_req_o && $stable(cas_addr_o) && $stable(cas_new_o));

  assert_cas_bits_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cas_req_o |-> cas_new_o[1] && ((cas_new_o ^ cas_cmp_o) & ~32'h0000_0082) == 32'h0
                  && (cas_new_o != cas_cmp_o));

  assert_cause_form_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o) |-> (rsp_cause_o[3:0] == 4'h2 || rsp_cause_o[3:0] == 4'h3)
                                     && rsp_cause_o[11:4] == 8'h0);

  assert_offset_kept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_fault_o) |-> rsp_pa_o[11:0] == rsp_va_o[11:0]);
endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .rd_req_o    (rd_req_o),
  .rd_addr_o   (rd_addr_o),
  .rd_ack_i    (rd_ack_i),
  .cas_req_o   (cas_req_o),
  .cas_addr_o  (cas_addr_o),
  .cas_cmp_o   (cas_cmp_o),
  .cas_new_o   (cas_new_o),
  .cas_ack_i   (cas_ack_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_fault_o (rsp_fault_o),
  .rsp_cause_o (rsp_cause_o),
  .rsp_pa_o    (rsp_pa_o),
  .rsp_va_o    (rsp_va_o)
);

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        xlat_en_i = 1'b0;
  logic        base_wr_i = 1'b0;
  logic [31:0] base_wdata_i = '0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_va_i = '0;
  logic [1:0]  req_kind_i = '0;
  logic        req_user_i = 1'b0;
  logic        rd_req_o;
  logic [31:0] rd_addr_o;
  logic        rd_ack_i = 1'b0;
  logic [31:0] rd_data_i = '0;
  logic        cas_req_o;
  logic [31:0] cas_addr_o, cas_cmp_o, cas_new_o;
  logic        cas_ack_i = 1'b0;
  logic        rsp_valid_o, rsp_fault_o;
  logic [31:0] rsp_cause_o, rsp_pa_o, rsp_va_o;

  always #2.5 clk_i = ~clk_i;

  pt_walker u_dut (.*);

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] mem [logic [31:0]];
  int lat = 0;
  bit race = 1'b0;
  int n_rd = 0, n_cas = 0, rd_cnt = 0, cas_cnt = 0;
  logic [31:0] rd_log [4];
  logic [31:0] cas_a_log, cas_c_log, cas_n_log;
  logic [31:0] base_exp;

  function automatic logic [31:0] mrd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // memory read responder
  initial forever begin
    @(negedge clk_i);
    if (rd_ack_i) begin
      rd_ack_i = 1'b0;
      rd_cnt = 0;
    end else if (rd_req_o) begin
      if (rd_cnt >= lat) begin
        rd_ack_i  = 1'b1;
        rd_data_i = mrd(rd_addr_o);
        if (n_rd < 4) rd_log[n_rd] = rd_addr_o;
        n_rd++;
      end else rd_cnt++;
    end
  end

  // swap responder
  initial forever begin
    @(negedge clk_i);
    if (cas_ack_i) begin
      cas_ack_i = 1'b0;
      cas_cnt = 0;
    end else if (cas_req_o) begin
      if (cas_cnt >= lat) begin
        cas_ack_i = 1'b1;
        cas_a_log = cas_addr_o;
        cas_c_log = cas_cmp_o;
        cas_n_log = cas_new_o;
        n_cas++;
        if (race) mem[cas_addr_o] = mrd(cas_addr_o) ^ 32'h0000_0100;
        if (mrd(cas_addr_o) == cas_cmp_o) mem[cas_addr_o] = cas_new_o;
      end else cas_cnt++;
    end
  end

  task automatic walk(input logic [31:0] va, input logic [1:0] kind, input bit usr,
                      input logic [31:0] l1pte, input logic [31:0] l2pte, input bit en);
    logic [31:0] l1a, l2a, e_pa, e_cause, e_new, race_val;
    bit e_fault, st, perm, e_upd;
    int e_rd;
    string tag;
    l1a = base_exp + {20'h0, va[31:22], 2'b00};
    l2a = {l1pte[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
    mem[l1a] = l1pte;
    mem[l2a] = l2pte;
    st = (kind == 2'd1) || (kind == 2'd3);
    case (kind)
      2'd0: perm = l2pte[2];
      2'd2: perm = l2pte[4];
      default: perm = l2pte[3];
    endcase
    e_fault = 1'b0; e_cause = 32'h0; e_pa = 32'h0; e_upd = 1'b0; e_new = l2pte; e_rd = 2;
    tag = "R8";
    if (!en) begin
      e_pa = va; e_rd = 0; tag = "R1";
    end else if (!l1pte[0]) begin
      e_fault = 1'b1; e_rd = 1; tag = "R3";
    end else if (!l2pte[0]) begin
      e_fault = 1'b1; tag = "R3";
    end else if (usr && !l2pte[5]) begin
      e_fault = 1'b1; tag = "R4";
    end else if (!perm) begin
      e_fault = 1'b1; tag = "R5";
    end else begin
      e_pa = {l2pte[31:12], va[11:0]};
      if (!l2pte[1]) e_new[1] = 1'b1;
      if (st && !l2pte[7]) e_new[7] = 1'b1;
      e_upd = (e_new != l2pte);
    end
    if (e_fault)
      e_cause = (kind == 2'd0 ? 32'h2000 : kind == 2'd2 ? 32'h0000 : 32'h3000) |
                (tag == "R4" ? 32'h3 : 32'h2);
    n_rd = 0; n_cas = 0;
    @(negedge clk_i);
    xlat_en_i = en; req_va_i = va; req_kind_i = kind; req_user_i = usr; req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    while (!rsp_valid_o) @(negedge clk_i);
    chk(rsp_fault_o == e_fault && (e_fault || rsp_pa_o == e_pa), tag,
        e_fault ? {31'h0, rsp_fault_o} : rsp_pa_o, e_fault ? 32'h1 : e_pa);
    chk(rsp_cause_o == e_cause, "R6 cause", rsp_cause_o, e_cause);
    chk(rsp_va_o == va, "R10 va", rsp_va_o, va);
    chk(n_rd == e_rd, "R2 read count", n_rd, e_rd);
    if (e_rd >= 1) chk(rd_log[0] == l1a, "R2 R9 L1 addr", rd_log[0], l1a);
    if (e_rd == 2) chk(rd_log[1] == l2a, "R2 L2 addr", rd_log[1], l2a);
    chk(n_cas == (e_upd ? 1 : 0), "R7 swap count", n_cas, e_upd ? 1 : 0);
    if (e_upd) begin
      chk(cas_a_log == l2a && cas_c_log == l2pte, "R7 swap target", cas_c_log, l2pte);
      chk(cas_n_log == e_new, "R7 swap value", cas_n_log, e_new);
      race_val = race ? (l2pte ^ 32'h100) : e_new;
      chk(mrd(l2a) == race_val, "R7 entry after swap", mrd(l2a), race_val);
    end
    @(negedge clk_i);
    chk(!rsp_valid_o && req_ready_o, "R10 single pulse", {31'h0, rsp_valid_o}, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] va, l1pte, l2pte;
    repeat (3) @(negedge clk_i);
    chk(req_ready_o && !rsp_valid_o && !rd_req_o && !cas_req_o, "R10 reset", {31'h0, req_ready_o}, 32'h1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o && !rd_req_o && !cas_req_o && !rsp_valid_o, "R10 idle", {31'h0, req_ready_o}, 32'h1);
    // R9: low bits of the base write are dropped
    base_wr_i = 1'b1; base_wdata_i = 32'h0000_5ABC; base_exp = 32'h0000_5000;
    @(negedge clk_i);
    base_wr_i = 1'b0;
    // R1 identity mapping
    for (int k = 0; k < 4; k++) begin
      walk(32'hDEAD_BEEF ^ (k * 32'h0101_0101), 2'(k), k[0], 32'h0, 32'h0, 1'b0);
    end
    // R3 first-level miss for every kind
    for (int k = 0; k < 4; k++) begin
      lat = k % 3;
      walk({10'h123, 10'h2AB, 12'h5C4}, 2'(k), 1'b1, 32'h0009_AFFE, 32'hFFFF_FFFF, 1'b1);
    end
    // full sweep: R3 R4 R5 R6 R7 R8
    for (int k = 0; k < 4; k++) begin
      for (int u = 0; u < 2; u++) begin
        for (int f = 0; f < 128; f++) begin
          lat = (f + k) % 3;
          va = {10'(f * 7 + 3), 10'(f * 13 + k), 12'(f * 37 + u)};
          l1pte = {20'(32'h9A + f), 12'hFF1};
          l2pte = {20'(32'hABCDE + f * 3), 4'h0, f[6], 1'b0, f[5:0]};
          walk(va, 2'(k), u[0], l1pte, l2pte, 1'b1);
        end
      end
    end
    // R7: swap loses the race, no retry, result unchanged
    race = 1'b1;
    for (int k = 0; k < 4; k++) begin
      lat = k % 3;
      walk({10'h3FF, 10'h001, 12'hFFC}, 2'(k), 1'b0, 32'h0007_7001, 32'h1234_503D, 1'b1);
    end
    race = 1'b0;
    // R9: second base value
    base_wr_i = 1'b1; base_wdata_i = 32'h0003_0FFF; base_exp = 32'h0003_0000;
    @(negedge clk_i);
    base_wr_i = 1'b0;
    walk({10'h000, 10'h3FF, 12'h001}, 2'd2, 1'b1, 32'h0008_8001, 32'h4444_40B7, 1'b1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule